// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the programmable register bank of a color LCD controller. Software reaches it through a plain word-indexed bus: `bus_idx` is the byte offset divided by four. Writes take effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_idx` and is valid in the same cycle. The bus has no stall and no back-pressure: every access completes in one cycle.

The bank keeps four timing words, the base addresses of the upper and lower panel halves, a control word, an interrupt mask and a raw interrupt status. It derives the panel width and height from timing-word fields and decodes the control word into a pixel-depth code, three ordering flags and an enable flag.

A frame counter runs while the controller is enabled and raises two status bits at once on every frame tick. A level interrupt is asserted while any unmasked status bit is set. Accesses that fall in the palette window are forwarded to an external palette store. The top eight words of the window return fixed identification bytes.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every register is zero. The interrupt is therefore low, the enable flag is low, the panel width reads 16 and the panel height reads 1.
- R2: Word indices 0–3 (timing), 4 (upper base) and 5 (lower base) read back what was last written to them. Index 11 returns the upper base and index 12 returns the lower base.
- R3: The panel width is ((timing0 & 0xFC) + 4) * 4. The panel height is (timing1 & 0x3FF) + 1.
- R4: The control word keeps bits [15:0]. The pixel-depth code is bits [3:1], BGR order is bit 8, big-endian bytes is bit 9 and big-endian pixels is bit 10. The enable flag is high only when bit 0 and bit 11 are both set.
- R5: With VARIANT=0 the mask is at index 6 and control is at index 7. With VARIANT 1 or 2 the two are swapped, for both reads and writes.
- R6: A write to index 10 clears every status bit that is 1 in the written value and leaves the other status bits unchanged.
- R7: Index 8 returns the 5-bit raw status. Index 9 returns raw AND mask. `irq` is high exactly while raw AND mask is non-zero.
- R8: While enabled, status bits 2 and 3 are both set every CLK_HZ/FRAME_HZ cycles. The first setting edge comes that many edges after the edge that wrote control. A disabled block sets no status bits.
- R9: Any write to the control word restarts the frame count from zero.
- R10: Indices 0x3F8–0x3FF return one identification byte each. VARIANT 0 and 1 return 10,11,04,00,0D,F0,05,B1 (hex). VARIANT 2 returns 11,11,24,00,0D,F0,05,B1. Writes to these indices change nothing.
- R11: Indices 0x80–0xFF form the palette window. A write there pulses `pal_we` with `pal_idx` = index[6:0] and `pal_wdata` = write data. A read there returns `pal_rdata`.
- R12: Any other index reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_idx | input | AW | Word index (byte offset / 4) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_idx`, same cycle |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette entry index |
| pal_wdata | output | DW | Palette write data |
| pal_rdata | input | DW | Palette read data |
| panel_width | output | 11 | Derived panel width in pixels |
| panel_height | output | 11 | Derived panel height in lines |
| pix_depth | output | 3 | Pixel-depth code |
| bgr_order | output | 1 | BGR color order |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within a byte |
| ctl_enabled | output | 1 | Enable and power both set |
| irq | output | 1 | Level interrupt |

## Verification
Two instances are exercised: VARIANT 0 and VARIANT 2, with a short frame period.

A vector table covers write and read-back of the storage words, the mirrored current-address indices, an undefined index and the identification bytes. Writing to the identification and undefined indices shows that ignored writes leave the read value unchanged.

Frame ticks are sampled one edge before and on the edge where they are due, so an off-by-one in the counter is caught. Rewriting the control word part way through a frame shows whether the count restarts or keeps its old phase.

Mask and clear patterns covering a single bit, both bits and all ones show that clear is bitwise and that the interrupt follows the masked status. Each field in the control and timing words is given a distinct value so the decoded outputs reveal any misrouted bit.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [3:0] {
    SEL_TIM, SEL_UPB, SEL_LPB, SEL_CTRL, SEL_MASK, SEL_RIS, SEL_MIS,
    SEL_ICR, SEL_UPC, SEL_LPC, SEL_PAL, SEL_ID, SEL_NONE
  } sel_e;

  localparam int ST_W = 5;
  localparam int ST_NEXT_BASE = 2;
  localparam int ST_VCOMP = 3;

  function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] i);
    case (i)
      3'd0: id_byte = ext ? 8'h11 : 8'h10;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = ext ? 8'h24 : 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
  import lcdc_pkg::*;
#(
  parameter int AW   = 10,
  parameter bit SWAP = 1'b0
) (
  input  logic [AW-1:0] idx,
  output sel_e          sel
);
  localparam int ID_LO  = (1 << AW) - 8;
  localparam int PAL_LO = 'h80;
  localparam int PAL_HI = 'h100;

  always_comb begin
    sel = SEL_NONE;
    if (int'(idx) >= ID_LO) sel = SEL_ID;
    else if (int'(idx) >= PAL_LO && int'(idx) < PAL_HI) sel = SEL_PAL;
    else if (int'(idx) < 16) begin
      case (idx[3:0])
        4'd0, 4'd1, 4'd2, 4'd3: sel = SEL_TIM;
        4'd4:  sel = SEL_UPB;
        4'd5:  sel = SEL_LPB;
        4'd6:  sel = SWAP ? SEL_CTRL : SEL_MASK;
        4'd7:  sel = SWAP ? SEL_MASK : SEL_CTRL;
        4'd8:  sel = SEL_RIS;
        4'd9:  sel = SEL_MIS;
        4'd10: sel = SEL_ICR;
        4'd11: sel = SEL_UPC;
        4'd12: sel = SEL_LPC;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_frame_tick.sv
module lcdc_frame_tick #(
  parameter int unsigned PERIOD = 833_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || !run)   cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R8: the count never passes the frame period
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  generate
    if (PERIOD > 1) begin : g_restart_chk
      // R9: a control write leaves a full frame before the next tick
      a_r9_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl
  import lcdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [ST_W-1:0] mask_d,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_d,
  input  logic            tick,
  output logic [ST_W-1:0] status,
  output logic [ST_W-1:0] mask,
  output logic            irq
);
  localparam logic [ST_W-1:0] TICK_BITS =
    ST_W'((1 << ST_NEXT_BASE) | (1 << ST_VCOMP));

  logic [ST_W-1:0] clr_bits;
  assign clr_bits = clr_we ? clr_d : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_bits) | (tick ? TICK_BITS : '0);
      if (mask_we) mask <= mask_d;
    end
  end

  assign irq = |(status & mask);

  // R8: a tick sets both frame bits
  a_r8_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (status[ST_NEXT_BASE] && status[ST_VCOMP]));
  // R6: cleared bits are zero afterwards when no tick collides
  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !tick) |=> ((status & $past(clr_d)) == '0));
  // R7: a zero mask holds the interrupt low
  a_r7_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int          VARIANT  = 0,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned FRAME_HZ = 60,
  parameter int          AW       = 10,
  parameter int          DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_idx,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pal_we,
  output logic [6:0]    pal_idx,
  output logic [DW-1:0] pal_wdata,
  input  logic [DW-1:0] pal_rdata,
  output logic [10:0]   panel_width,
  output logic [10:0]   panel_height,
  output logic [2:0]    pix_depth,
  output logic          bgr_order,
  output logic          be_bytes,
  output logic          be_pixels,
  output logic          ctl_enabled,
  output logic          irq
);
  localparam bit SWAP = (VARIANT != 0);
  localparam bit EXT  = (VARIANT == 2);
  localparam int unsigned PERIOD_RAW = CLK_HZ / FRAME_HZ;
  localparam int unsigned PERIOD = (PERIOD_RAW == 0) ? 1 : PERIOD_RAW;
  localparam int CTRL_W = 16;

  sel_e sel;
  logic [DW-1:0]     tim_q [4];
  logic [DW-1:0]     upb_q, lpb_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ST_W-1:0]   status, mask;
  logic              tick, ctrl_we;

  lcdc_addr_decode #(.AW(AW), .SWAP(SWAP)) u_dec (
    .idx (bus_idx),
    .sel (sel)
  );

  assign ctrl_we = bus_wr && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_TIM:  tim_q[bus_idx[1:0]] <= bus_wdata;
        SEL_UPB:  upb_q  <= bus_wdata;
        SEL_LPB:  lpb_q  <= bus_wdata;
        SEL_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctl_enabled = ctrl_q[0] && ctrl_q[11];
  assign pix_depth   = ctrl_q[3:1];
  assign bgr_order   = ctrl_q[8];
  assign be_bytes    = ctrl_q[9];
  assign be_pixels   = ctrl_q[10];

  logic [10:0] w_words;
  assign w_words      = {3'b000, tim_q[0][7:2], 2'b00} + 11'd4;
  assign panel_width  = {w_words[8:0], 2'b00};
  assign panel_height = {1'b0, tim_q[1][9:0]} + 11'd1;

  lcdc_frame_tick #(.PERIOD(PERIOD)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_enabled),
    .restart (ctrl_we),
    .tick    (tick)
  );

  lcdc_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (bus_wr && (sel == SEL_MASK)),
    .mask_d  (bus_wdata[ST_W-1:0]),
    .clr_we  (bus_wr && (sel == SEL_ICR)),
    .clr_d   (bus_wdata[ST_W-1:0]),
    .tick    (tick),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  assign pal_we    = bus_wr && (sel == SEL_PAL);
  assign pal_idx   = bus_idx[6:0];
  assign pal_wdata = bus_wdata;

  always_comb begin
    case (sel)
      SEL_TIM:          bus_rdata = tim_q[bus_idx[1:0]];
      SEL_UPB, SEL_UPC: bus_rdata = upb_q;
      SEL_LPB, SEL_LPC: bus_rdata = lpb_q;
      SEL_CTRL:         bus_rdata = DW'(ctrl_q);
      SEL_MASK:         bus_rdata = DW'(mask);
      SEL_RIS:          bus_rdata = DW'(status);
      SEL_MIS:          bus_rdata = DW'(status & mask);
      SEL_PAL:          bus_rdata = pal_rdata;
      SEL_ID:           bus_rdata = DW'(id_byte(EXT, bus_idx[2:0]));
      default:          bus_rdata = '0;
    endcase
  end

  // R12: writes outside the map leave storage untouched
  a_r12_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(upb_q) &&
                                      $stable(lpb_q) && $stable(mask)));
  // R11: palette strobe only inside the palette window
  a_r11_pal_window: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> (bus_wr && int'(bus_idx) >= 'h80 && int'(bus_idx) < 'h100));
  // R8: no frame bits appear while disabled and nothing is set
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enabled && !(bus_wr && sel == SEL_CTRL) && status == '0) |=> (status == '0));
endmodule

// File: tb/lcdc_regbank_tb.sv
module lcdc_regbank_tb;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_b = 1'b0, wr_e = 1'b0;
  logic [9:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_b, rd_e, palw_b, palw_e, palr_b;
  logic        pwe_b, pwe_e, irq_b, irq_e, en_b, en_e;
  logic [6:0]  pidx_b, pidx_e;
  logic [10:0] w_b, h_b, w_e, h_e;
  logic [2:0]  dep_b, dep_e;
  logic        bgr_b, beb_b, bep_b, bgr_e, beb_e, bep_e;

  assign palr_b = 32'h5A00_0000 | {25'b0, pidx_b};

  lcdc_regbank #(.VARIANT(0), .CLK_HZ(PER * 60)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_idx(idx), .bus_wdata(wdata),
    .bus_rdata(rd_b), .pal_we(pwe_b), .pal_idx(pidx_b), .pal_wdata(palw_b),
    .pal_rdata(palr_b), .panel_width(w_b), .panel_height(h_b), .pix_depth(dep_b),
    .bgr_order(bgr_b), .be_bytes(beb_b), .be_pixels(bep_b), .ctl_enabled(en_b),
    .irq(irq_b));

  lcdc_regbank #(.VARIANT(2), .CLK_HZ(PER * 60)) u_dut_ext (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_e), .bus_idx(idx), .bus_wdata(wdata),
    .bus_rdata(rd_e), .pal_we(pwe_e), .pal_idx(pidx_e), .pal_wdata(palw_e),
    .pal_rdata(32'h0), .panel_width(w_e), .panel_height(h_e), .pix_depth(dep_e),
    .bgr_order(bgr_e), .be_bytes(beb_e), .be_pixels(bep_e), .ctl_enabled(en_e),
    .irq(irq_e));

  int checks = 0, errors = 0;

  // {write, index, wdata, expected read}
  localparam int NV = 14;
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 10'd0,     32'h1234_5678, 32'h1234_5678},
    {1'b1, 10'd1,     32'hABCD_07FF, 32'hABCD_07FF},
    {1'b1, 10'd2,     32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {1'b1, 10'd3,     32'h0000_0055, 32'h0000_0055},
    {1'b1, 10'd4,     32'h8000_1000, 32'h8000_1000},
    {1'b1, 10'd5,     32'h8000_2000, 32'h8000_2000},
    {1'b0, 10'd11,    32'h0,         32'h8000_1000},
    {1'b0, 10'd12,    32'h0,         32'h8000_2000},
    {1'b1, 10'd13,    32'hFFFF_FFFF, 32'h0},
    {1'b0, 10'h3F8,   32'h0,         32'h10},
    {1'b0, 10'h3FA,   32'h0,         32'h04},
    {1'b0, 10'h3FF,   32'h0,         32'hB1},
    {1'b1, 10'h3F8,   32'h55,        32'h10},
    {1'b0, 10'd10,    32'h0,         32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit ext, input logic [9:0] i, input logic [31:0] d);
    @(negedge clk);
    idx = i; wdata = d;
    if (ext) wr_e = 1'b1; else wr_b = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_b = 1'b0; wr_e = 1'b0;
  endtask

  task automatic peek(input bit ext, input logic [9:0] i, input logic [31:0] exp, input string tag);
    idx = i;
    #1;
    chk(tag, ext ? rd_e : rd_b, exp);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(0, 10'd7, 32'h0, "R1 control");
    chk("R1 irq", {31'b0, irq_b}, 32'h0);
    chk("R1 enabled", {31'b0, en_b}, 32'h0);
    chk("R1 width", {21'b0, w_b}, 32'd16);
    chk("R1 height", {21'b0, h_b}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][74]) wr(0, VEC[v][73:64], VEC[v][63:32]);
      peek(0, VEC[v][73:64], VEC[v][31:0], $sformatf("R2,R10,R12 vector %0d", v));
    end

    // R3 geometry
    chk("R3 width", {21'b0, w_b}, 32'd496);
    chk("R3 height", {21'b0, h_b}, 32'd1024);

    // R8 first tick timing
    wr(0, 10'd7, 32'h0801);
    edges(PER - 1);
    peek(0, 10'd8, 32'h0, "R8 before tick");
    edges(1);
    peek(0, 10'd8, 32'hC, "R8 tick sets bits");
    wr(0, 10'd7, 32'h0);
    chk("R7 irq masked", {31'b0, irq_b}, 32'h0);
    peek(0, 10'd9, 32'h0, "R7 masked status zero");
    wr(0, 10'd6, 32'h4);
    #1 chk("R7 irq on", {31'b0, irq_b}, 32'h1);
    peek(0, 10'd9, 32'h4, "R7 masked status");
    wr(0, 10'd10, 32'h4);
    peek(0, 10'd8, 32'h8, "R6 single clear");
    chk("R7 irq off", {31'b0, irq_b}, 32'h0);
    wr(0, 10'd6, 32'hC);
    #1 chk("R7 irq bit3", {31'b0, irq_b}, 32'h1);
    wr(0, 10'd10, 32'hFFFF_FFFF);
    peek(0, 10'd8, 32'h0, "R6 clear all");
    chk("R7 irq cleared", {31'b0, irq_b}, 32'h0);
    edges(3 * PER);
    peek(0, 10'd8, 32'h0, "R8 disabled no tick");

    // R9 restart on control rewrite
    wr(0, 10'd7, 32'h0801);
    repeat (4) @(posedge clk);
    wr(0, 10'd7, 32'h0801);
    edges(PER - 1);
    peek(0, 10'd8, 32'h0, "R9 restarted count");
    edges(1);
    peek(0, 10'd8, 32'hC, "R9 tick after restart");
    wr(0, 10'd7, 32'h0);

    // R4 control fields
    wr(0, 10'd7, 32'h070B);
    chk("R4 depth", {29'b0, dep_b}, 32'd5);
    chk("R4 order flags", {29'b0, bgr_b, beb_b, bep_b}, 32'h7);
    chk("R4 no power", {31'b0, en_b}, 32'h0);
    peek(0, 10'd7, 32'h070B, "R4 control readback");
    peek(0, 10'd6, 32'hC, "R5 base mask at 6");

    // R5 and R10 on the extended variant
    wr(1, 10'd6, 32'h0801);
    chk("R5 ext enable via 6", {31'b0, en_e}, 32'h1);
    peek(1, 10'd7, 32'h0, "R5 ext mask at 7");
    wr(1, 10'd7, 32'h3);
    peek(1, 10'd7, 32'h3, "R5 ext mask write");
    peek(1, 10'd6, 32'h0801, "R5 ext control read");
    peek(1, 10'h3F8, 32'h11, "R10 ext id0");
    peek(1, 10'h3FA, 32'h24, "R10 ext id2");

    // R11 palette window
    @(negedge clk);
    idx = 10'h85; wdata = 32'hABC; wr_b = 1'b1;
    #1 chk("R11 pal strobe", {24'b0, pwe_b, pidx_b}, {24'b0, 1'b1, 7'd5});
    chk("R11 pal data", palw_b, 32'hABC);
    @(posedge clk);
    @(negedge clk);
    wr_b = 1'b0;
    #1 chk("R11 strobe drops", {31'b0, pwe_b}, 32'h0);
    peek(0, 10'h93, 32'h5A00_0013, "R11 pal read");

    summary();
    $finish;
  end
endmodule